// File: doc/BRIEF.md
# Scheduled Battery Level Flag Sampler

This block holds the supply status flags of a battery-backed timekeeper. It receives three raw comparator outputs: one that reports the main supply below its brownout level, and two that report the backup battery below its upper and lower thresholds. The comparators are asynchronous, so each one first passes through a flop synchronizer. The main-supply flag tracks its comparator continuously, but only while the device runs from the main supply.

The two battery flags are snapshots, not mirrors. On the main supply they are sampled once a minute, when the BCD seconds count first takes the value 59. On battery they are sampled once per ten minutes, when the BCD minutes count enters a units digit of 9 or 0. A sample taken on battery is kept in a shadow copy and shown only when the main supply returns.

A one-shot test request forces a sample at once. A clear input zeroes the visible flags.

Top module: `supply_flag_sampler`

## Requirements
- R1: After reset all three flag outputs read 0.
- R2: While `main_mode` is 1, `low_main` follows `cmp_main_low` with three clock cycles of latency (two synchronizer stages plus the flag register), both setting and clearing.
- R3: While `main_mode` is 0, changes on `cmp_main_low` have no effect on `low_main`.
- R4: On the main supply the battery flags change only at a sample; an automatic sample occurs in the cycle `sec_bcd` first equals 8'h59.
- R5: Only one automatic sample is taken per qualifying count value; comparator changes while the count holds 8'h59 are ignored.
- R6: A one-cycle pulse on `test_set` raises an internal test bit on the next edge. That bit causes a single sample on the following edge and then clears, so the flags update two edges after the pulse.
- R7: A battery flag that is set clears at the next sample whose comparator reading shows the battery above threshold.
- R8: With `main_mode` 0, a sample occurs when `min_bcd[3:0]` first becomes 9 or 0, counting consecutive x9 and x0 values as one match. The sampled result stays hidden until `main_mode` returns to 1, and is shown on that edge.
- R9: If no sample occurs during a battery interval, the battery flags are unchanged on return to the main supply.
- R10: `flag_clr` zeroes all three flags on the next edge and takes priority over a sample in the same cycle.
- R11: The 85% and 75% flags are sampled from their own comparators and can hold different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_mode | input | 1 | 1 = running from main supply, 0 = battery |
| cmp_main_low | input | 1 | Async comparator: main supply below trip level |
| cmp_bat85_low | input | 1 | Async comparator: battery below upper threshold |
| cmp_bat75_low | input | 1 | Async comparator: battery below lower threshold |
| sec_bcd | input | 8 | BCD seconds count |
| min_bcd | input | 8 | BCD minutes count |
| test_set | input | 1 | Write of 1 to the test-sample bit |
| flag_clr | input | 1 | Manual clear of all flags |
| low_main | output | 1 | Low main-supply flag |
| low_bat85 | output | 1 | Battery below upper threshold flag |
| low_bat75 | output | 1 | Battery below lower threshold flag |

## Verification
Comparator readings are changed away from the sampling point, while seconds dwell on 59, and just before a manual test sample. This tells a true snapshot apart from a continuous mirror, and a single-shot trigger apart from a level trigger. The two battery comparators are driven to opposite values, which exposes any swap or sharing between the flags. Battery intervals are run both with and without a minute boundary, to separate hidden latching from no change at all. A clear coinciding with a sample shows which of the two has priority.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int NUM_CMP = 3;
    localparam int IDX_MAIN = 0;
    localparam int IDX_B85 = 1;
    localparam int IDX_B75 = 2;

    typedef struct packed {
        logic low_main;
        logic vis85;
        logic vis75;
        logic sh85;
        logic sh75;
        logic seen;
        logic test;
        logic mode;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{
        low_main: 1'b0, vis85: 1'b0, vis75: 1'b0, sh85: 1'b0,
        sh75: 1'b0, seen: 1'b0, test: 1'b0, mode: 1'b1
    };
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sfs_sample_trig.sv
module sfs_sample_trig #(
    parameter logic [7:0] SEC_MARK  = 8'h59,
    parameter logic [3:0] MIN_DIG_A = 4'h9,
    parameter logic [3:0] MIN_DIG_B = 4'h0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_mode,
    input  logic [7:0] sec_bcd,
    input  logic [7:0] min_bcd,
    input  logic       test_pend,
    output logic       auto_fire,
    output logic       fire
);
    logic match;
    logic match_d, match_q;

    always_comb begin
        if (main_mode) match = (sec_bcd == SEC_MARK);
        else           match = (min_bcd[3:0] == MIN_DIG_A) || (min_bcd[3:0] == MIN_DIG_B);
        match_d   = match;
        auto_fire = match && !match_q;
        fire      = auto_fire || test_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_d;
    end

    // R5: an automatic sample never repeats in the following cycle
    p_single_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        auto_fire |=> !auto_fire);
endmodule

// File: rtl/supply_flag_sampler.sv
module supply_flag_sampler #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] SEC_MARK    = 8'h59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_mode,
    input  logic       cmp_main_low,
    input  logic       cmp_bat85_low,
    input  logic       cmp_bat75_low,
    input  logic [7:0] sec_bcd,
    input  logic [7:0] min_bcd,
    input  logic       test_set,
    input  logic       flag_clr,
    output logic       low_main,
    output logic       low_bat85,
    output logic       low_bat75
);
    import sfs_pkg::*;

    logic [NUM_CMP-1:0] cmp_raw, cmp_s;
    logic               auto_fire, fire;
    logic               mode_return, mode_leave;
    flag_state_t        st_d, st_q;

    assign cmp_raw[IDX_MAIN] = cmp_main_low;
    assign cmp_raw[IDX_B85]  = cmp_bat85_low;
    assign cmp_raw[IDX_B75]  = cmp_bat75_low;

    sfs_sync #(.W(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cmp_raw), .dout(cmp_s)
    );

    sfs_sample_trig #(.SEC_MARK(SEC_MARK)) u_trig (
        .clk(clk), .rst_n(rst_n), .main_mode(main_mode),
        .sec_bcd(sec_bcd), .min_bcd(min_bcd), .test_pend(st_q.test),
        .auto_fire(auto_fire), .fire(fire)
    );

    always_comb begin
        st_d        = st_q;
        mode_return = main_mode && !st_q.mode;
        mode_leave  = !main_mode && st_q.mode;
        st_d.mode   = main_mode;
        st_d.test   = st_q.test ? 1'b0 : test_set;
        if (main_mode) st_d.low_main = cmp_s[IDX_MAIN];
        if (mode_leave) st_d.seen = 1'b0;
        if (mode_return && st_q.seen) begin
            st_d.vis85 = st_q.sh85;
            st_d.vis75 = st_q.sh75;
            st_d.seen  = 1'b0;
        end
        if (fire) begin
            if (main_mode) begin
                st_d.vis85 = cmp_s[IDX_B85];
                st_d.vis75 = cmp_s[IDX_B75];
            end else begin
                st_d.sh85 = cmp_s[IDX_B85];
                st_d.sh75 = cmp_s[IDX_B75];
                st_d.seen = 1'b1;
            end
        end
        if (flag_clr) begin
            st_d.low_main = 1'b0;
            st_d.vis85    = 1'b0;
            st_d.vis75    = 1'b0;
            st_d.seen     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_RESET;
        else        st_q <= st_d;
    end

    assign low_main  = st_q.low_main;
    assign low_bat85 = st_q.vis85;
    assign low_bat75 = st_q.vis75;

    // R3: main flag frozen on battery
    p_main_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_mode && !flag_clr) |=> $stable(low_main));
    // R4: battery flags move only on a sample or a return to main supply
    p_bat_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !mode_return && !flag_clr) |=> ($stable(low_bat85) && $stable(low_bat75)));
    // R6: a pending test bit always produces a sample
    p_test_samples_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.test |-> fire);
    // R10: clear empties every flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!low_main && !low_bat85 && !low_bat75));
endmodule

// File: tb/supply_flag_sampler_test.sv
module supply_flag_sampler_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_mode = 1'b1;
    logic cmp_main_low = 1'b0, cmp_bat85_low = 1'b0, cmp_bat75_low = 1'b0;
    logic [7:0] sec_bcd = 8'h00, min_bcd = 8'h15;
    logic test_set = 1'b0, flag_clr = 1'b0;
    logic low_main, low_bat85, low_bat75;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] flags;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    supply_flag_sampler uut (
        .clk(clk), .rst_n(rst_n), .main_mode(main_mode),
        .cmp_main_low(cmp_main_low), .cmp_bat85_low(cmp_bat85_low),
        .cmp_bat75_low(cmp_bat75_low), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
        .test_set(test_set), .flag_clr(flag_clr),
        .low_main(low_main), .low_bat85(low_bat85), .low_bat75(low_bat75)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_flags(input logic [2:0] f, input string req);
        exp_t e;
        e.flags = f;
        e.req   = req;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares {low_main, low_bat85, low_bat75}
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            @(negedge clk);
            e = exp_q.pop_front();
            checks++;
            if ({low_main, low_bat85, low_bat75} !== e.flags) begin
                fails++;
                $display("FAIL %s: flags actual=%b expected=%b", e.req,
                         {low_main, low_bat85, low_bat75}, e.flags);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        expect_flags(3'b000, "R1");
        // R2: follow comparator in main mode
        cmp_main_low = 1'b1; tick(4);
        expect_flags(3'b100, "R2");
        cmp_main_low = 1'b0; tick(4);
        expect_flags(3'b000, "R2");
        // R4: no sample before seconds reach 59
        cmp_bat85_low = 1'b1; tick(4);
        expect_flags(3'b000, "R4");
        sec_bcd = 8'h58; tick(1);
        sec_bcd = 8'h59; tick(2);
        expect_flags(3'b010, "R4/R11");
        // R5: holding 59 does not resample
        cmp_bat85_low = 1'b0; cmp_bat75_low = 1'b1; tick(5);
        expect_flags(3'b010, "R5");
        sec_bcd = 8'h00; tick(2);
        expect_flags(3'b010, "R4");
        // R7: next sample clears the upper flag, sets the lower one
        sec_bcd = 8'h59; tick(2);
        expect_flags(3'b001, "R7/R11");
        // R6: test request samples immediately, then only once
        sec_bcd = 8'h00; cmp_bat85_low = 1'b1; cmp_bat75_low = 1'b0; tick(4);
        expect_flags(3'b001, "R6");
        test_set = 1'b1; tick(1);
        test_set = 1'b0; tick(2);
        expect_flags(3'b010, "R6");
        cmp_bat85_low = 1'b0; tick(5);
        expect_flags(3'b010, "R6");
        // R10: clear, and clear beats a coincident sample
        flag_clr = 1'b1; tick(1);
        flag_clr = 1'b0; tick(1);
        expect_flags(3'b000, "R10");
        cmp_bat85_low = 1'b1; tick(4);
        sec_bcd = 8'h59; flag_clr = 1'b1; tick(1);
        flag_clr = 1'b0; tick(2);
        expect_flags(3'b000, "R10");
        sec_bcd = 8'h00; tick(1);
        // R3: main flag ignores comparator on battery
        main_mode = 1'b0; tick(2);
        cmp_main_low = 1'b1; tick(5);
        expect_flags(3'b000, "R3");
        // R8: x9 minute samples but stays hidden until return
        min_bcd = 8'h19; tick(2);
        expect_flags(3'b000, "R8");
        cmp_bat85_low = 1'b0; tick(4);
        min_bcd = 8'h20; tick(2);
        min_bcd = 8'h21; tick(2);
        main_mode = 1'b1; tick(2);
        expect_flags(3'b110, "R8");
        // R9: battery interval without a boundary leaves flags alone
        cmp_main_low = 1'b0; tick(4);
        flag_clr = 1'b1; tick(1);
        flag_clr = 1'b0; tick(1);
        cmp_bat85_low = 1'b1; cmp_bat75_low = 1'b1; tick(4);
        main_mode = 1'b0; tick(2);
        min_bcd = 8'h25; tick(3);
        main_mode = 1'b1; tick(2);
        expect_flags(3'b000, "R9");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule